// File: doc/BRIEF.md
# I2C Controller Status Word

This block holds the status word of an I2C controller that works both as bus master and as addressed slave. The bus engine sends it single-cycle event strobes: Start, repeated Start, Stop, the start of a master transmission, the end of an acknowledge slot with the sampled level, a bus collision, an address match of a given kind, a received slave byte, and a shift-to-receive transfer. The block also holds the receive byte register and the transmit byte register, because overflow and write-collision detection depend on how full they are. Each flag has its own set rule and its own clear rule. Some clear on Stop, some on a bus event, and some only when software writes to them.

Received bytes leave through a valid/ready pair. `rx_valid` is high while the receive register holds an unread byte. A byte is consumed in a cycle where both `rx_valid` and `rx_ready` are high. Software loads bytes for transmission through a second valid/ready pair. `tx_wr_ready` is low while a byte is pending or while a master transmission is in progress. A write offered while ready is low is dropped rather than stalled, and it raises the write-collision flag. The engine releases the pending byte with `ev_tx_taken`. Every flag is a register, so its effect on `status` appears in the cycle after the strobe. `tx_wr_ready` follows register state with no extra delay.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset every status bit is 0, `rx_data` and `tx_data` are 0, `tx_wr_ready` is 1, and status bits 13, 12, 11, 3 and 2 are 0 at all times.
- R2: Bit 15 (acknowledge status) takes the value of `ack_value` (1 = NACK, 0 = ACK) in the cycle after an `ev_ack_done` strobe, and otherwise holds its value.
- R3: Bit 14 (master transmit in progress) sets after `ev_mtx_begin` and clears after `ev_ack_done`. If both strobes arrive in the same cycle, the set wins.
- R4: Bit 10 (bus collision) sets after `ev_collision`. A status write with bit 10 at 0 clears it, and a written 1 has no effect. If a hardware set and a software clear arrive in the same cycle, the set wins.
- R5: `ev_addr_match` with `addr_kind` 1 (general call) sets bit 9. With `addr_kind` 2 (second byte of a 10-bit address) it sets bit 8. `ev_stop` clears both bits, and a set in the same cycle as a Stop wins. Kinds 0 (7-bit) and 3 change neither bit.
- R6: Bit 5 (last byte was data) clears after any `ev_addr_match` and sets after `ev_slave_byte`. If both arrive in the same cycle, the clear wins.
- R7: Bit 4 (Stop seen last) sets after `ev_stop` and clears after `ev_start` or `ev_rstart`. If a Stop arrives in the same cycle as a Start, the Stop wins.
- R8: `ev_rx_load` moves `rx_shift_data` into `rx_data` and sets bit 1 (`rx_valid`) when the register is empty or is being consumed in the same cycle. A consume with no load clears bit 1.
- R9: `ev_rx_load` while bit 1 is 1 and `rx_ready` is 0 sets bit 6 (receive overflow). In that case `rx_data` keeps its old byte and bit 1 stays 1. Bit 6 is cleared only by a status write with bit 6 at 0, and a hardware set in the same cycle wins.
- R10: `tx_wr_ready` is 1 exactly when bit 0 (transmit full) and bit 14 are both 0. An accepted write loads `tx_data` and sets bit 0. `ev_tx_taken` clears bit 0.
- R11: A write offered while `tx_wr_ready` is 0 is dropped, so `tx_data` and bit 0 are unchanged, and it sets bit 7 (write collision). Bit 7 is cleared only by a status write with bit 7 at 0, and a hardware set in the same cycle wins.
- R12: Status writes have no effect on any bit other than 10, 7 and 6, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition strobe |
| ev_rstart | input | 1 | Repeated Start strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_mtx_begin | input | 1 | Master transmission begins |
| ev_ack_done | input | 1 | End of acknowledge slot |
| ack_value | input | 1 | Sampled acknowledge level, 1 = NACK |
| ev_collision | input | 1 | Bus collision during master operation |
| ev_addr_match | input | 1 | Slave address match strobe |
| addr_kind | input | 2 | 0 = 7-bit, 1 = general call, 2 = 10-bit second byte |
| ev_slave_byte | input | 1 | Slave data byte received |
| ev_rx_load | input | 1 | Shift register to receive register transfer |
| rx_shift_data | input | DATA_W | Byte from the shift register |
| rx_valid | output | 1 | Receive register holds an unread byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W | Receive register |
| tx_wr_valid | input | 1 | Software offers a transmit byte |
| tx_wr_data | input | DATA_W | Offered transmit byte |
| tx_wr_ready | output | 1 | Transmit register can take a byte |
| ev_tx_taken | input | 1 | Engine has taken the pending byte |
| tx_data | output | DATA_W | Transmit register |
| sw_stat_wr | input | 1 | Software status write strobe |
| sw_stat_wdata | input | 16 | Status write value, 0 clears a clearable bit |
| status | output | 16 | Status word |

## Verification
The bench builds the block with the default `DATA_W` of 8. A byte-wide data path lets random stimulus reach every register value quickly, so a dropped write or an overwritten byte on overflow shows up as a wrong value rather than as a coincidental match. Random strobes are weighted so that events collide often in the same cycle. This covers the set-versus-clear priorities, a consume and a load in the same cycle, and Stop meeting Start. Directed steps cover the corner cases separately.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W = 16;

  localparam int B_ACK   = 15;
  localparam int B_TXACT = 14;
  localparam int B_COLL  = 10;
  localparam int B_GCALL = 9;
  localparam int B_A10   = 8;
  localparam int B_WCOL  = 7;
  localparam int B_OVF   = 6;
  localparam int B_DATA  = 5;
  localparam int B_STOP  = 4;
  localparam int B_RXF   = 1;
  localparam int B_TXF   = 0;

  // software-clearable flags, in the order of the sticky flag instances
  localparam int N_CLR = 3;
  localparam int CLR_POS [N_CLR] = '{B_COLL, B_WCOL, B_OVF};

  typedef enum logic [1:0] {
    ADDR_7BIT  = 2'd0,
    ADDR_GCALL = 2'd1,
    ADDR_10BIT = 2'd2,
    ADDR_RSVD  = 2'd3
  } addr_kind_e;
endpackage

// File: rtl/stat_sticky_flag.sv
module stat_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (hw_set)  flag_q <= 1'b1;
    else if (sw_clr)  flag_q <= 1'b0;
  end

  // R4, R9, R11: a hardware set beats a same-cycle software clear
  a_r4_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_q);
  // R4, R9, R11: only a software clear lowers the flag
  a_r4_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_set) |=> !flag_q);
  a_r9_only_sw_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_clr) |=> flag_q);
endmodule

// File: rtl/stat_bus_flags.sv
module stat_bus_flags
  import i2c_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_rstart,
  input  logic       ev_stop,
  input  logic       ev_mtx_begin,
  input  logic       ev_ack_done,
  input  logic       ack_value,
  input  logic       ev_addr_match,
  input  addr_kind_e addr_kind,
  input  logic       ev_slave_byte,
  output logic       ack_q,
  output logic       txact_q,
  output logic       gcall_q,
  output logic       a10_q,
  output logic       data_q,
  output logic       stop_q
);
  logic gc_hit, a10_hit, any_start;

  assign gc_hit    = ev_addr_match && (addr_kind == ADDR_GCALL);
  assign a10_hit   = ev_addr_match && (addr_kind == ADDR_10BIT);
  assign any_start = ev_start || ev_rstart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      txact_q <= 1'b0;
      gcall_q <= 1'b0;
      a10_q   <= 1'b0;
      data_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (ev_ack_done) ack_q <= ack_value;

      if (ev_mtx_begin)     txact_q <= 1'b1;
      else if (ev_ack_done) txact_q <= 1'b0;

      if (gc_hit)       gcall_q <= 1'b1;
      else if (ev_stop) gcall_q <= 1'b0;

      if (a10_hit)      a10_q <= 1'b1;
      else if (ev_stop) a10_q <= 1'b0;

      if (ev_addr_match)      data_q <= 1'b0;
      else if (ev_slave_byte) data_q <= 1'b1;

      if (ev_stop)        stop_q <= 1'b1;
      else if (any_start) stop_q <= 1'b0;
    end
  end

  a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_done |=> (ack_q == $past(ack_value)));
  a_r2_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ack_done |=> $stable(ack_q));
  a_r3_txact_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mtx_begin |=> txact_q);
  a_r3_txact_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack_done && !ev_mtx_begin) |=> !txact_q);
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_addr_match) |=> (!gcall_q && !a10_q));
  a_r6_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_match |=> !data_q);
  a_r7_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> stop_q);
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (any_start && !ev_stop) |=> !stop_q);
endmodule

// File: rtl/stat_rx_hold.sv
module stat_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_load,
  input  logic [DATA_W-1:0] rx_shift_data,
  input  logic              rx_ready,
  output logic              rx_full_q,
  output logic [DATA_W-1:0] rx_data_q,
  output logic              ovf_evt
);
  logic keep_byte;

  // the held byte survives this cycle unless the consumer takes it
  assign keep_byte = rx_full_q && !rx_ready;
  assign ovf_evt   = ev_rx_load && keep_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full_q <= 1'b0;
      rx_data_q <= '0;
    end else if (ev_rx_load && !keep_byte) begin
      rx_full_q <= 1'b1;
      rx_data_q <= rx_shift_data;
    end else if (rx_full_q && rx_ready) begin
      rx_full_q <= 1'b0;
    end
  end

  a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_load && !keep_byte) |=> (rx_full_q && rx_data_q == $past(rx_shift_data)));
  a_r8_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_q && rx_ready && !ev_rx_load) |=> !rx_full_q);
  a_r9_overflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (rx_full_q && $stable(rx_data_q)));
endmodule

// File: rtl/stat_tx_hold.sv
module stat_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txact,
  input  logic              tx_wr_valid,
  input  logic [DATA_W-1:0] tx_wr_data,
  input  logic              ev_tx_taken,
  output logic              tx_wr_ready,
  output logic              tx_full_q,
  output logic [DATA_W-1:0] tx_data_q,
  output logic              wcol_evt
);
  logic accept;

  assign tx_wr_ready = !tx_full_q && !txact;
  assign accept      = tx_wr_valid && tx_wr_ready;
  assign wcol_evt    = tx_wr_valid && !tx_wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0;
      tx_data_q <= '0;
    end else if (accept) begin
      tx_full_q <= 1'b1;
      tx_data_q <= tx_wr_data;
    end else if (ev_tx_taken) begin
      tx_full_q <= 1'b0;
    end
  end

  a_r10_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tx_full_q && tx_data_q == $past(tx_wr_data)));
  a_r10_taken_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_taken && !accept) |=> !tx_full_q);
  a_r11_drop_write: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> $stable(tx_data_q));
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_mtx_begin,
  input  logic              ev_ack_done,
  input  logic              ack_value,
  input  logic              ev_collision,
  input  logic              ev_addr_match,
  input  logic [1:0]        addr_kind,
  input  logic              ev_slave_byte,
  input  logic              ev_rx_load,
  input  logic [DATA_W-1:0] rx_shift_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_wr_valid,
  input  logic [DATA_W-1:0] tx_wr_data,
  output logic              tx_wr_ready,
  input  logic              ev_tx_taken,
  output logic [DATA_W-1:0] tx_data,
  input  logic              sw_stat_wr,
  input  logic [STAT_W-1:0] sw_stat_wdata,
  output logic [STAT_W-1:0] status
);
  logic ack_q, txact_q, gcall_q, a10_q, data_q, stop_q;
  logic rx_full_q, tx_full_q, ovf_evt, wcol_evt;
  logic [N_CLR-1:0] sticky_set, sticky_q;
  logic unused_wbits;

  stat_bus_flags u_bus (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start     (ev_start),
    .ev_rstart    (ev_rstart),
    .ev_stop      (ev_stop),
    .ev_mtx_begin (ev_mtx_begin),
    .ev_ack_done  (ev_ack_done),
    .ack_value    (ack_value),
    .ev_addr_match(ev_addr_match),
    .addr_kind    (addr_kind_e'(addr_kind)),
    .ev_slave_byte(ev_slave_byte),
    .ack_q        (ack_q),
    .txact_q      (txact_q),
    .gcall_q      (gcall_q),
    .a10_q        (a10_q),
    .data_q       (data_q),
    .stop_q       (stop_q)
  );

  stat_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_rx_load   (ev_rx_load),
    .rx_shift_data(rx_shift_data),
    .rx_ready     (rx_ready),
    .rx_full_q    (rx_full_q),
    .rx_data_q    (rx_data),
    .ovf_evt      (ovf_evt)
  );

  stat_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .txact      (txact_q),
    .tx_wr_valid(tx_wr_valid),
    .tx_wr_data (tx_wr_data),
    .ev_tx_taken(ev_tx_taken),
    .tx_wr_ready(tx_wr_ready),
    .tx_full_q  (tx_full_q),
    .tx_data_q  (tx_data),
    .wcol_evt   (wcol_evt)
  );

  // order follows CLR_POS: collision, write collision, overflow
  assign sticky_set = {ovf_evt, wcol_evt, ev_collision};

  for (genvar gi = 0; gi < N_CLR; gi++) begin : g_sticky
    stat_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .hw_set(sticky_set[gi]),
      .sw_clr(sw_stat_wr && !sw_stat_wdata[CLR_POS[gi]]),
      .flag_q(sticky_q[gi])
    );
  end

  assign unused_wbits = ^{sw_stat_wdata[15:11], sw_stat_wdata[9:8], sw_stat_wdata[5:0]};

  assign rx_valid = rx_full_q;

  always_comb begin
    status          = '0;
    status[B_ACK]   = ack_q;
    status[B_TXACT] = txact_q;
    status[B_GCALL] = gcall_q;
    status[B_A10]   = a10_q;
    status[B_DATA]  = data_q;
    status[B_STOP]  = stop_q;
    status[B_RXF]   = rx_full_q;
    status[B_TXF]   = tx_full_q;
    for (int i = 0; i < N_CLR; i++) status[CLR_POS[i]] = sticky_q[i];
  end

  // R12: a status write alone leaves the hardware-owned bits where they were
  a_r12_hw_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stat_wr && !ev_ack_done && !ev_mtx_begin && !ev_stop && !ev_start && !ev_rstart
     && !ev_addr_match && !ev_slave_byte)
    |=> ($stable(status[15:14]) && $stable(status[9:8]) && $stable(status[5:4])));
  a_r10_ready_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (status[B_TXF] || status[B_TXACT]) |-> !tx_wr_ready);
endmodule

// File: tb/i2c_stat_flags_tb.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start, ev_rstart, ev_stop, ev_mtx_begin, ev_ack_done, ack_value;
  logic ev_collision, ev_addr_match, ev_slave_byte, ev_rx_load, rx_ready;
  logic [1:0] addr_kind;
  logic [DW-1:0] rx_shift_data, tx_wr_data, rx_data, tx_data;
  logic tx_wr_valid, ev_tx_taken, sw_stat_wr, rx_valid, tx_wr_ready;
  logic [15:0] sw_stat_wdata, status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_stat_flags #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .ev_mtx_begin(ev_mtx_begin), .ev_ack_done(ev_ack_done),
    .ack_value(ack_value), .ev_collision(ev_collision), .ev_addr_match(ev_addr_match),
    .addr_kind(addr_kind), .ev_slave_byte(ev_slave_byte), .ev_rx_load(ev_rx_load),
    .rx_shift_data(rx_shift_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_wr_valid(tx_wr_valid), .tx_wr_data(tx_wr_data),
    .tx_wr_ready(tx_wr_ready), .ev_tx_taken(ev_tx_taken), .tx_data(tx_data),
    .sw_stat_wr(sw_stat_wr), .sw_stat_wdata(sw_stat_wdata), .status(status)
  );

  // reference state, written from the requirements
  bit m_ack, m_txact, m_coll, m_gc, m_a10, m_wcol, m_ovf, m_data, m_stop, m_rxf, m_txf;
  logic [DW-1:0] m_rxd, m_txd;

  function automatic logic [15:0] exp_status();
    logic [15:0] s = '0;
    s[15] = m_ack;  s[14] = m_txact; s[10] = m_coll; s[9] = m_gc; s[8] = m_a10;
    s[7] = m_wcol;  s[6] = m_ovf;    s[5] = m_data;  s[4] = m_stop;
    s[1] = m_rxf;   s[0] = m_txf;
    return s;
  endfunction

  function automatic string req_of_bit(int b);
    case (b)
      15: return "R2";
      14: return "R3";
      10: return "R4";
      9, 8: return "R5";
      7: return "R11";
      6: return "R9";
      5: return "R6";
      4: return "R7";
      1: return "R8";
      0: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_mtx_begin = 0; ev_ack_done = 0;
    ack_value = 0; ev_collision = 0; ev_addr_match = 0; addr_kind = 0;
    ev_slave_byte = 0; ev_rx_load = 0; rx_shift_data = 0; rx_ready = 0;
    tx_wr_valid = 0; tx_wr_data = 0; ev_tx_taken = 0; sw_stat_wr = 0; sw_stat_wdata = '1;
  endtask

  task automatic model_step();
    bit rdy = !m_txf && !m_txact;
    bit keep = m_rxf && !rx_ready;
    bit n_ack = m_ack, n_txact = m_txact, n_coll = m_coll, n_gc = m_gc, n_a10 = m_a10;
    bit n_wcol = m_wcol, n_ovf = m_ovf, n_data = m_data, n_stop = m_stop;
    bit n_rxf = m_rxf, n_txf = m_txf;
    logic [DW-1:0] n_rxd = m_rxd, n_txd = m_txd;
    if (ev_ack_done) n_ack = ack_value;
    if (ev_mtx_begin) n_txact = 1; else if (ev_ack_done) n_txact = 0;
    if (ev_collision) n_coll = 1; else if (sw_stat_wr && !sw_stat_wdata[10]) n_coll = 0;
    if (ev_addr_match && addr_kind == 2'd1) n_gc = 1; else if (ev_stop) n_gc = 0;
    if (ev_addr_match && addr_kind == 2'd2) n_a10 = 1; else if (ev_stop) n_a10 = 0;
    if (ev_addr_match) n_data = 0; else if (ev_slave_byte) n_data = 1;
    if (ev_stop) n_stop = 1; else if (ev_start || ev_rstart) n_stop = 0;
    if (tx_wr_valid && !rdy) n_wcol = 1; else if (sw_stat_wr && !sw_stat_wdata[7]) n_wcol = 0;
    if (ev_rx_load && keep) n_ovf = 1; else if (sw_stat_wr && !sw_stat_wdata[6]) n_ovf = 0;
    if (ev_rx_load && !keep) begin n_rxf = 1; n_rxd = rx_shift_data; end
    else if (m_rxf && rx_ready) n_rxf = 0;
    if (tx_wr_valid && rdy) begin n_txf = 1; n_txd = tx_wr_data; end
    else if (ev_tx_taken) n_txf = 0;
    m_ack = n_ack; m_txact = n_txact; m_coll = n_coll; m_gc = n_gc; m_a10 = n_a10;
    m_wcol = n_wcol; m_ovf = n_ovf; m_data = n_data; m_stop = n_stop;
    m_rxf = n_rxf; m_txf = n_txf; m_rxd = n_rxd; m_txd = n_txd;
  endtask

  task automatic compare();
    logic [15:0] e = exp_status();
    checks++;
    if (status !== e) begin
      errors++;
      for (int b = 15; b >= 0; b--)
        if (status[b] !== e[b])
          $display("FAIL %s status[%0d] actual=%b expected=%b", req_of_bit(b), b, status[b], e[b]);
    end
    check("R8", "rx_data", 32'(rx_data), 32'(m_rxd));
    check("R11", "tx_data", 32'(tx_data), 32'(m_txd));
    check("R10", "ready/valid", {30'd0, tx_wr_ready, rx_valid},
          {30'd0, (!m_txf && !m_txact), m_rxf});
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
    compare();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd24681));
    clear_inputs();
    m_ack = 0; m_txact = 0; m_coll = 0; m_gc = 0; m_a10 = 0; m_wcol = 0;
    m_ovf = 0; m_data = 0; m_stop = 0; m_rxf = 0; m_txf = 0; m_rxd = '0; m_txd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check("R1", "status after reset", 32'(status), 32'h0);
    check("R1", "ready after reset", {31'd0, tx_wr_ready}, 32'd1);
    rst_n = 1'b1;
    tick();

    // R2 / R3: master transmit with NACK, begin and ack-done in one cycle
    ev_mtx_begin = 1; tick();
    ev_ack_done = 1; ack_value = 1; ev_mtx_begin = 1; tick();
    check("R3", "begin wins over ack end", {31'd0, status[14]}, 32'd1);
    ev_ack_done = 1; ack_value = 0; tick();
    check("R2", "ack value", {30'd0, status[15:14]}, 32'd0);

    // R4: set and clear in one cycle, then writing 1 keeps, then 0 clears
    ev_collision = 1; sw_stat_wr = 1; sw_stat_wdata = 16'h0000; tick();
    check("R4", "set wins", {31'd0, status[10]}, 32'd1);
    sw_stat_wr = 1; sw_stat_wdata = 16'hFFFF; tick();
    sw_stat_wr = 1; sw_stat_wdata = 16'hFBFF; tick();
    check("R4", "software clear", {31'd0, status[10]}, 32'd0);

    // R5 / R6 / R7 / R12
    ev_addr_match = 1; addr_kind = 2'd1; ev_slave_byte = 1; tick();
    ev_addr_match = 1; addr_kind = 2'd2; ev_stop = 1; ev_start = 1; tick();
    check("R5", "gcall and a10 after stop with set", {30'd0, status[9:8]}, 32'd1);
    check("R7", "stop wins over start", {31'd0, status[4]}, 32'd1);
    ev_slave_byte = 1; tick();
    sw_stat_wr = 1; sw_stat_wdata = 16'h0000; tick();
    check("R12", "hw bits after zero write", {27'd0, status[9:8], status[5:4], 1'b0}, 32'h0E);
    ev_addr_match = 1; addr_kind = 2'd0; ev_rstart = 1; tick();
    check("R6", "match clears data flag", {31'd0, status[5]}, 32'd0);
    ev_stop = 1; tick();

    // R8 / R9: fill, overflow, load with consume
    ev_rx_load = 1; rx_shift_data = 8'hA5; tick();
    ev_rx_load = 1; rx_shift_data = 8'h3C; tick();
    check("R9", "overflow keeps byte", 32'(rx_data), 32'hA5);
    ev_rx_load = 1; rx_shift_data = 8'h5A; rx_ready = 1; tick();
    check("R8", "load while consumed", 32'(rx_data), 32'h5A);
    rx_ready = 1; sw_stat_wr = 1; sw_stat_wdata = 16'hFFBF; tick();
    check("R9", "overflow cleared", {30'd0, status[6], status[1]}, 32'd0);

    // R10 / R11: accept, dropped write, release
    tx_wr_valid = 1; tx_wr_data = 8'h81; tick();
    tx_wr_valid = 1; tx_wr_data = 8'h7E; tick();
    check("R11", "dropped write", {23'd0, status[7], tx_data}, 32'h181);
    ev_tx_taken = 1; tick();
    check("R10", "taken frees register", {31'd0, tx_wr_ready}, 32'd1);
    sw_stat_wr = 1; sw_stat_wdata = 16'hFF7F; tick();

    // random traffic, events weighted to collide
    for (int n = 0; n < 4000; n++) begin
      ev_start      = ($urandom % 12) == 0;
      ev_rstart     = ($urandom % 14) == 0;
      ev_stop       = ($urandom % 10) == 0;
      ev_mtx_begin  = ($urandom % 8) == 0;
      ev_ack_done   = ($urandom % 6) == 0;
      ack_value     = 1'($urandom);
      ev_collision  = ($urandom % 16) == 0;
      ev_addr_match = ($urandom % 7) == 0;
      addr_kind     = 2'($urandom);
      ev_slave_byte = ($urandom % 5) == 0;
      ev_rx_load    = ($urandom % 5) == 0;
      rx_shift_data = DW'($urandom);
      rx_ready      = ($urandom % 4) == 0;
      tx_wr_valid   = ($urandom % 4) == 0;
      tx_wr_data    = DW'($urandom);
      ev_tx_taken   = ($urandom % 6) == 0;
      sw_stat_wr    = ($urandom % 8) == 0;
      sw_stat_wdata = 16'($urandom);
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule